// File: doc/BRIEF.md
# Banked Interrupt Controller

This block collects peripheral request lines into banks of up to 32 sources and drives one interrupt line per bank towards a processor. Each source can be made level-sensitive or edge-sensitive on its own, and each source has its own active sense: high or low for level, rising or falling for edge. Edge events are held in a pending latch until software acknowledges them through a write-one-to-clear register. Software can also raise an edge-mode source by writing to a set register.

Each bank also reports which source a dispatcher should serve first. This is the lowest-numbered bit that is both pending and enabled, given as a binary index with a valid flag. Software reaches every bank through a plain 32-bit register bus. The bus has a byte address, a write strobe, write data and a combinational read path. A write takes effect on the clock edge at which the strobe is high.

Top module: `banked_irq_ctrl`

## Requirements
- R1: Bank b occupies byte addresses b*0x18 to b*0x18+0x17. Within a bank, offset 0x0 is status, 0x4 enable, 0x8 set, 0xC clear, 0x10 polarity and 0x14 edge select. Set and clear read as zero. Source N is bank N>>5, bit N&31, where `irq_src[N]` is the N-th input bit.
- R2: After reset every enable bit is 0 and every polarity bit is 1. Every edge-select bit is 0, except bits 13, 14 and 15 of bank 0, so bank 0 edge select reads 0x0000E000. No source is pending.
- R3: `irq_out[b]` is 1 in the same cycle that status AND enable of bank b is nonzero, and 0 otherwise. `pick_valid[b]` equals `irq_out[b]`.
- R4: Writing clear with a bit at 1 removes the latched pending state of that edge-mode source from the next cycle on. Bits written as 0 leave their sources unchanged.
- R5: For a level-mode source, the status bit equals the input when its polarity bit is 1 and the inverted input when it is 0. It follows the input without a clock delay.
- R6: An edge-mode source with polarity 1 becomes pending on a 0-to-1 input transition. With polarity 0 it becomes pending on a 1-to-0 transition. The status bit shows it after the first clock edge at which the new input level is sampled, and it stays pending after the input returns.
- R7: `pick_idx[b]` gives the lowest bit number that is both pending and enabled in bank b. This holds for bit 0, bit 31 and any position between them.
- R8: Writing set with a bit at 1 makes that edge-mode source pending from the next cycle. The same write has no effect on a level-mode source.
- R9: If an edge is captured in the same cycle as a clear of that bit, the bit remains pending.
- R10: Writing clear to a level-mode source whose input is still active leaves its status bit at 1.
- R11: Banks are independent. Activity and register writes in one bank do not change the status, enable or interrupt output of another bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_src | input | NUM_BANKS*SRC_W (128) | Raw request lines, source N at bit N |
| irq_out | output | NUM_BANKS (4) | One interrupt line per bank |
| pick_idx | output | NUM_BANKS*IDX_W (20) | Lowest pending-and-enabled index per bank, bank b at bits b*IDX_W and up |
| pick_valid | output | NUM_BANKS (4) | Index of the same bank is meaningful |

## Verification
The bench builds the block with its defaults: four banks of 32 sources, a 0x18 stride and an 8-bit address. This configuration reaches the stride boundaries between all four banks and the edge-select preset of bank 0. It also covers the full 5-bit index range, from bit 0 to bit 31. The preset edge sources in bank 0 make rising capture, falling capture through a cleared polarity bit, software set, partial clear and the capture-versus-clear collision testable without first reprogramming the mode. Level behaviour and the pick order are exercised in banks 1 and 3, and bank 2 shows that a pending source whose enable is off stays silent.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int REG_BYTES     = 4;
   localparam int REGS_PER_BANK = 6;
   localparam int BANK_SPAN     = REG_BYTES * REGS_PER_BANK;

   typedef enum logic [2:0] {
      SEL_STATUS = 3'd0,
      SEL_ENABLE = 3'd1,
      SEL_SET    = 3'd2,
      SEL_CLEAR  = 3'd3,
      SEL_POL    = 3'd4,
      SEL_EDGE   = 3'd5
   } reg_sel_e;
endpackage

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
   parameter int W     = 32,
   parameter int IDX_W = 5
) (
   input  logic [W-1:0]     req,
   output logic [IDX_W-1:0] idx,
   output logic             valid
);
   // Scan from the top down so the last hit is the lowest bit.
   always_comb begin
      idx   = '0;
      valid = 1'b0;
      for (int i = W - 1; i >= 0; i--) begin
         if (req[i]) begin
            idx   = IDX_W'(i);
            valid = 1'b1;
         end
      end
   end
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
   import irq_pkg::*;
#(
   parameter int NUM_BANKS   = 4,
   parameter int ADDR_W      = 8,
   parameter int BANK_STRIDE = 24
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 we,
   output logic [NUM_BANKS-1:0] bank_hit,
   output logic [NUM_BANKS-1:0] bank_we,
   output reg_sel_e             sel
);
   localparam int AW1 = ADDR_W + 1;

   logic [2:0] sel_arr [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam logic [AW1-1:0] BASE = AW1'(b * BANK_STRIDE);
      logic [AW1-1:0] a_ext;
      logic [AW1-1:0] off;
      assign a_ext = {1'b0, addr};
      assign off   = a_ext - BASE;
      assign bank_hit[b] = (a_ext >= BASE) && (off < AW1'(BANK_SPAN))
                           && (addr[1:0] == 2'b00);
      assign sel_arr[b]  = off[4:2];
   end

   always_comb begin
      logic [2:0] acc;
      acc = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bank_hit[b]) acc = acc | sel_arr[b];
      end
      sel = reg_sel_e'(acc);
   end

   assign bank_we = bank_hit & {NUM_BANKS{we}};
endmodule

// File: rtl/irq_bank.sv
module irq_bank
   import irq_pkg::*;
#(
   parameter int              SRC_W     = 32,
   parameter int              IDX_W     = 5,
   parameter logic [SRC_W-1:0] POL_INIT  = '1,
   parameter logic [SRC_W-1:0] EDGE_INIT = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_W-1:0] src,
   input  logic             wr_en,
   input  reg_sel_e         sel,
   input  logic [31:0]      wdata,
   output logic [31:0]      rd_data,
   output logic             irq,
   output logic [IDX_W-1:0] pick_idx,
   output logic             pick_valid
);
   logic [SRC_W-1:0] en_q, pol_q, edge_q, prev_q, latch_q;
   logic [SRC_W-1:0] adj, rise, status, pending, wbits;
   logic [SRC_W-1:0] set_mask, clr_mask, latch_d;
   logic             wr_set, wr_clr;

   assign wbits  = wdata[SRC_W-1:0];
   assign wr_set = wr_en && (sel == SEL_SET);
   assign wr_clr = wr_en && (sel == SEL_CLEAR);

   // Active-sense adjust: polarity 1 passes the input, 0 inverts it.
   assign adj  = ~(src ^ pol_q);
   assign rise = adj & ~prev_q;

   assign set_mask = wr_set ? wbits : '0;
   assign clr_mask = wr_clr ? wbits : '0;
   // Capture and set are ORed after the clear, so they win a collision.
   assign latch_d  = ((latch_q & ~clr_mask) | rise | set_mask) & edge_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= '0;
         pol_q   <= POL_INIT;
         edge_q  <= EDGE_INIT;
         prev_q  <= '0;
         latch_q <= '0;
      end else begin
         prev_q  <= adj;
         latch_q <= latch_d;
         if (wr_en && sel == SEL_ENABLE) en_q   <= wbits;
         if (wr_en && sel == SEL_POL)    pol_q  <= wbits;
         if (wr_en && sel == SEL_EDGE)   edge_q <= wbits;
      end
   end

   assign status  = (latch_q & edge_q) | (adj & ~edge_q);
   assign pending = status & en_q;
   assign irq     = |pending;

   always_comb begin
      unique case (sel)
         SEL_STATUS: rd_data = 32'(status);
         SEL_ENABLE: rd_data = 32'(en_q);
         SEL_POL:    rd_data = 32'(pol_q);
         SEL_EDGE:   rd_data = 32'(edge_q);
         default:    rd_data = '0;
      endcase
   end

   irq_lowest_pick #(.W(SRC_W), .IDX_W(IDX_W)) u_pick (
      .req   (pending),
      .idx   (pick_idx),
      .valid (pick_valid)
   );

   logic [SRC_W-1:0] below_idx;
   assign below_idx = (SRC_W'(1) << pick_idx) - SRC_W'(1);

   AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> ((latch_q & $past(wbits & ~rise & edge_q)) == '0)); // R4
   AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> ((latch_q & $past(wbits & edge_q)) == $past(wbits & edge_q))); // R8
   AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rise & edge_q)) |=> ((latch_q & $past(rise & edge_q)) == $past(rise & edge_q))); // R9
   AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      pick_valid |-> (pending[pick_idx] && ((pending & below_idx) == '0))); // R7
   AST_IRQ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      irq == pick_valid); // R3
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
   import irq_pkg::*;
#(
   parameter int          NUM_BANKS   = 4,
   parameter int          SRC_W       = 32,
   parameter int          ADDR_W      = 8,
   parameter int          BANK_STRIDE = 24,
   parameter logic [31:0] BANK0_EDGE  = 32'h0000_E000,
   localparam int         IDX_W       = (SRC_W > 1) ? $clog2(SRC_W) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic                       bus_we,
   input  logic [31:0]                bus_wdata,
   output logic [31:0]                bus_rdata,
   input  logic [NUM_BANKS*SRC_W-1:0] irq_src,
   output logic [NUM_BANKS-1:0]       irq_out,
   output logic [NUM_BANKS*IDX_W-1:0] pick_idx,
   output logic [NUM_BANKS-1:0]       pick_valid
);
   initial begin : p_param_check
      if (SRC_W < 1 || SRC_W > 32) $fatal(1, "SRC_W must be 1..32");
      if (BANK_STRIDE < BANK_SPAN) $fatal(1, "BANK_STRIDE below bank span");
      if (NUM_BANKS < 1) $fatal(1, "NUM_BANKS must be positive");
      if (ADDR_W < 5) $fatal(1, "ADDR_W too narrow");
      if (NUM_BANKS * BANK_STRIDE > (1 << ADDR_W)) $fatal(1, "banks exceed address space");
   end

   logic [NUM_BANKS-1:0] bank_hit, bank_we;
   reg_sel_e             sel;
   logic [31:0]          bank_rd [NUM_BANKS];

   irq_reg_decode #(
      .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .BANK_STRIDE(BANK_STRIDE)
   ) u_dec (
      .addr     (bus_addr),
      .we       (bus_we),
      .bank_hit (bank_hit),
      .bank_we  (bank_we),
      .sel      (sel)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam logic [SRC_W-1:0] EDGE_INIT = (b == 0) ? BANK0_EDGE[SRC_W-1:0] : '0;
      irq_bank #(
         .SRC_W(SRC_W), .IDX_W(IDX_W), .POL_INIT('1), .EDGE_INIT(EDGE_INIT)
      ) u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .src        (irq_src[b*SRC_W +: SRC_W]),
         .wr_en      (bank_we[b]),
         .sel        (sel),
         .wdata      (bus_wdata),
         .rd_data    (bank_rd[b]),
         .irq        (irq_out[b]),
         .pick_idx   (pick_idx[b*IDX_W +: IDX_W]),
         .pick_valid (pick_valid[b])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bank_hit[b]) bus_rdata = bus_rdata | bank_rd[b];
      end
   end

   AST_ONE_BANK_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_hit)); // R1
   AST_WRITE_IN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      (|bank_we) |-> bus_we); // R11
endmodule

// File: tb/banked_irq_ctrl_bench.sv
module banked_irq_ctrl_bench;
   localparam int NB = 4;
   localparam int SW = 32;
   localparam int IW = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [7:0]        bus_addr = '0;
   logic              bus_we = 1'b0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [NB*SW-1:0]  irq_src = '0;
   logic [NB-1:0]     irq_out;
   logic [NB*IW-1:0]  pick_idx;
   logic [NB-1:0]     pick_valid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   banked_irq_ctrl u_banked_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src),
      .irq_out(irq_out), .pick_idx(pick_idx), .pick_valid(pick_valid)
   );

   localparam int O_STAT = 'h0, O_EN = 'h4, O_SET = 'h8, O_CLR = 'hC, O_POL = 'h10, O_EDGE = 'h14;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input int bank, input int off, input logic [31:0] data);
      @(negedge clk);
      bus_addr  = 8'(bank * 24 + off);
      bus_wdata = data;
      bus_we    = 1'b1;
      @(posedge clk);
      #1 bus_we = 1'b0;
   endtask

   task automatic rd(input int bank, input int off, output logic [31:0] v);
      @(negedge clk);
      bus_addr = 8'(bank * 24 + off);
      bus_we   = 1'b0;
      #1 v = bus_rdata;
   endtask

   task automatic expect_reg(input int bank, input int off, input logic [31:0] exp, input string req);
      logic [31:0] v;
      rd(bank, off, v);
      check(v === exp, req, v, exp);
   endtask

   task automatic drive_src(input int n, input logic v);
      @(negedge clk);
      irq_src[n] = v;
   endtask

   task automatic t_reset();
      for (int b = 0; b < NB; b++) begin
         expect_reg(b, O_EN, 32'h0, "R2 enable");
         expect_reg(b, O_POL, 32'hFFFF_FFFF, "R2 polarity");
         expect_reg(b, O_EDGE, (b == 0) ? 32'h0000_E000 : 32'h0, "R2 edge");
         expect_reg(b, O_STAT, 32'h0, "R2 status");
      end
      check(irq_out === 4'b0, "R2 irq_out", 32'(irq_out), 32'h0);
   endtask

   task automatic t_map();
      wr(2, O_EN, 32'hA5A5_0000);
      expect_reg(2, O_EN, 32'hA5A5_0000, "R1 enable bank2");
      expect_reg(1, O_EN, 32'h0, "R11 bank1 enable untouched");
      expect_reg(3, O_EN, 32'h0, "R11 bank3 enable untouched");
      expect_reg(2, O_SET, 32'h0, "R1 set reads zero");
      expect_reg(2, O_CLR, 32'h0, "R1 clear reads zero");
      wr(2, O_EN, 32'h0);
   endtask

   task automatic t_level();
      wr(1, O_EN, 32'hFFFF_FFFF);
      drive_src(32 + 4, 1'b1);
      #1;
      check(irq_out[1] === 1'b1, "R3 irq same cycle", 32'(irq_out), 32'h2);
      expect_reg(1, O_STAT, 32'h10, "R5 level high");
      check(pick_idx[1*IW +: IW] === 5'd4, "R7 idx bank1", 32'(pick_idx[1*IW +: IW]), 32'd4);
      wr(1, O_CLR, 32'h10);
      expect_reg(1, O_STAT, 32'h10, "R10 clear on active level");
      wr(1, O_POL, 32'hFFFF_FFEF);
      expect_reg(1, O_STAT, 32'h0, "R5 inverted with input high");
      check(irq_out[1] === 1'b0, "R3 irq low", 32'(irq_out), 32'h0);
      drive_src(32 + 4, 1'b0);
      #1;
      check(irq_out[1] === 1'b1, "R5 inverted with input low", 32'(irq_out), 32'h2);
      wr(1, O_POL, 32'hFFFF_FFFF);
      expect_reg(1, O_STAT, 32'h0, "R5 restored");
      wr(1, O_EN, 32'h0);
   endtask

   task automatic t_edge();
      wr(0, O_EN, 32'hFFFF_FFFF);
      drive_src(13, 1'b1);
      #1;
      check(irq_out[0] === 1'b0, "R6 not before clock", 32'(irq_out), 32'h0);
      expect_reg(0, O_STAT, 32'h2000, "R6 rising captured");
      drive_src(13, 1'b0);
      expect_reg(0, O_STAT, 32'h2000, "R6 held after input drops");
      drive_src(15, 1'b1);
      drive_src(15, 1'b0);
      expect_reg(0, O_STAT, 32'hA000, "R6 second source");
      wr(0, O_CLR, 32'h2000);
      expect_reg(0, O_STAT, 32'h8000, "R4 partial clear");
      wr(0, O_CLR, 32'h8000);
      expect_reg(0, O_STAT, 32'h0, "R4 clear all");
      // falling-edge mode on bit 14
      drive_src(14, 1'b1);
      wr(0, O_POL, 32'hFFFF_BFFF);
      wr(0, O_CLR, 32'h4000);
      expect_reg(0, O_STAT, 32'h0, "R4 cleared before fall");
      drive_src(14, 1'b0);
      expect_reg(0, O_STAT, 32'h4000, "R6 falling captured");
      wr(0, O_POL, 32'hFFFF_FFFF);
      wr(0, O_CLR, 32'h4000);
      expect_reg(0, O_STAT, 32'h0, "R4 clear after fall");
   endtask

   task automatic t_set();
      wr(0, O_SET, 32'h0000_8008);
      expect_reg(0, O_STAT, 32'h8000, "R8 set edge only");
      check(pick_idx[0 +: IW] === 5'd15, "R7 idx after set", 32'(pick_idx[0 +: IW]), 32'd15);
      wr(0, O_CLR, 32'h8000);
      expect_reg(0, O_STAT, 32'h0, "R8 cleared");
   endtask

   task automatic t_same_cycle();
      @(negedge clk);
      irq_src[13] = 1'b1;
      bus_addr  = 8'(O_CLR);
      bus_wdata = 32'h2000;
      bus_we    = 1'b1;
      @(posedge clk);
      #1 bus_we = 1'b0;
      expect_reg(0, O_STAT, 32'h2000, "R9 capture beats clear");
      drive_src(13, 1'b0);
      wr(0, O_CLR, 32'h2000);
      expect_reg(0, O_STAT, 32'h0, "R9 later clear");
      wr(0, O_EN, 32'h0);
   endtask

   task automatic t_pick();
      wr(3, O_EN, 32'hFFFF_FFFF);
      @(negedge clk);
      irq_src[96 + 20] = 1'b1;
      irq_src[96 + 9]  = 1'b1;
      #1;
      check(pick_valid[3] === 1'b1 && pick_idx[3*IW +: IW] === 5'd9, "R7 lowest of two",
            32'(pick_idx[3*IW +: IW]), 32'd9);
      wr(3, O_EN, 32'hFFFF_FDFF);
      #1;
      check(pick_idx[3*IW +: IW] === 5'd20, "R7 masked lower", 32'(pick_idx[3*IW +: IW]), 32'd20);
      @(negedge clk);
      irq_src[96 + 20] = 1'b0;
      irq_src[96 + 9]  = 1'b0;
      irq_src[96 + 31] = 1'b1;
      #1;
      check(pick_idx[3*IW +: IW] === 5'd31, "R7 top bit", 32'(pick_idx[3*IW +: IW]), 32'd31);
      @(negedge clk);
      irq_src[96 + 0] = 1'b1;
      #1;
      check(pick_idx[3*IW +: IW] === 5'd0, "R7 bit zero", 32'(pick_idx[3*IW +: IW]), 32'd0);
      @(negedge clk);
      irq_src[96 + 0]  = 1'b0;
      irq_src[96 + 31] = 1'b0;
      #1;
      check(pick_valid[3] === 1'b0 && irq_out[3] === 1'b0, "R3 idle bank3",
            32'({pick_valid[3], irq_out[3]}), 32'h0);
      wr(3, O_EN, 32'h0);
   endtask

   task automatic t_banks();
      drive_src(64 + 0, 1'b1);
      expect_reg(2, O_STAT, 32'h1, "R11 bank2 status");
      check(irq_out === 4'b0, "R11 disabled bank silent", 32'(irq_out), 32'h0);
      expect_reg(1, O_STAT, 32'h0, "R11 bank1 status untouched");
      expect_reg(3, O_STAT, 32'h0, "R11 bank3 status untouched");
      drive_src(64 + 0, 1'b0);
   endtask

   initial begin : p_main
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_map();
      t_level();
      t_edge();
      t_set();
      t_same_cycle();
      t_pick();
      t_banks();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : p_watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule